// File: doc/BRIEF.md
# NMI Status and Mask Controller

This block collects non-maskable interrupt sources behind a small byte-wide I/O register interface, in the style of a legacy PC platform. It decodes two I/O ports. The status/control port latches a system-error pulse as an NMI source, shows the live level of timer channel 2, and shows a bit that flips on every refresh pulse. Through the same port, software gates the speaker output and drives the gate of timer channel 2. The mask port holds a global NMI mask bit and seven scratch bits.

The NMI output is a level: the enabled, pending error source, suppressed while the global mask is set. A pending source is cleared through its enable bit and not by writing a one to the status bit. Software writes the enable bit as 1 to clear the source and disable it, then writes it as 0 to enable it again.

The NMI output stays high while any source is pending, so a source that arrives during service makes no new edge. Software creates a fresh edge by setting the global mask and then clearing it. The timer, the refresh generator and the processor's edge detector lie outside the block.

Top module: `nmi_ctl_top`

## Requirements
- R1: After reset, the status/control port (address 061h) reads 00h when the timer channel 2 level is 0. The mask port (address 070h) reads 00h. The NMI, speaker and timer-gate outputs are all 0.
- R2: An error pulse sets status bit 7 at the next clock edge unless enable bit 2 is 1 after that cycle's write. With the mask bit at 0, the NMI output then goes high.
- R3: Writing status/control bit 2 as 1 clears bit 7 and holds it at 0 while bit 2 stays 1. Error pulses in that time are dropped. A clear and an error pulse in the same cycle leave bit 7 at 0. Writing bit 2 back to 0 does not set bit 7.
- R4: Status/control bit 5 reads the current level of the timer channel 2 input.
- R5: Status/control bit 4 reads 0 after reset and inverts after every refresh pulse.
- R6: The speaker output equals status/control bit 1 ANDed with the timer channel 2 level.
- R7: Status/control bit 0 drives the timer-gate output. Bit 3 is stored as written and read back, with no other effect.
- R8: Mask-port bit 7 set to 1 holds the NMI output at 0 even when a source is pending. Set to 0, it lets a pending source drive the output high. Mask-port bits 6:0 read back as written.
- R9: Writes to status/control bits 7, 6, 5 and 4 have no effect. Bit 6 always reads 0.
- R10: Writes to any address other than the two ports change nothing, and reads of such addresses return 00h.
- R11: The NMI output is a level. A further error pulse while a source is pending keeps the output high with no falling edge. Setting the mask bit and then clearing it drives the output low and then high again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| io_addr | input | ADDR_W | I/O address |
| io_wr | input | 1 | Write strobe, one cycle per write |
| io_wdata | input | 8 | Write data |
| io_rdata | output | 8 | Read data for the addressed port, 00h for any other address |
| err_pulse | input | 1 | System-error pulse, one cycle |
| refresh_pulse | input | 1 | Refresh-cycle pulse, one cycle |
| tmr2_out | input | 1 | Timer channel 2 output level |
| tmr2_gate | output | 1 | Timer channel 2 gate enable |
| spkr_out | output | 1 | Gated speaker output |
| nmi_out | output | 1 | NMI level to the processor |

## Verification
The bench builds the block with its default parameters: a 16-bit address with the ports at 061h and 070h. Because the whole address is decoded, the neighbouring addresses 062h and 071h can be written and read to show that neither port aliases onto them. The defaults also make it possible to order an error pulse, a clear write and a mask toggle to the exact cycle. The bench uses this to check that the clear wins against a simultaneous pulse, and that a mask toggle drives the level low and then high while a source is pending.

// File: rtl/nmi_pkg.sv
package nmi_pkg;

    typedef enum logic [1:0] {
        SEL_NONE = 2'd0,
        SEL_CTRL = 2'd1,
        SEL_MASK = 2'd2
    } port_sel_e;

    // writable part of the status/control port (bits 3:0)
    typedef struct packed {
        logic spare;
        logic err_dis;
        logic spk_en;
        logic t2_en;
    } ctl_wr_t;

    // mask port
    typedef struct packed {
        logic       nmi_off;
        logic [6:0] scratch;
    } mask_t;

    // read view of the status/control port
    typedef struct packed {
        logic    err_stat;
        logic    zero6;
        logic    t2_lvl;
        logic    refr_tog;
        ctl_wr_t wr;
    } ctl_view_t;

    function automatic logic [7:0] build_ctl_view(
        input logic    err_stat,
        input logic    t2_lvl,
        input logic    refr_tog,
        input ctl_wr_t wr
    );
        ctl_view_t v;
        v.err_stat = err_stat;
        v.zero6    = 1'b0;
        v.t2_lvl   = t2_lvl;
        v.refr_tog = refr_tog;
        v.wr       = wr;
        return v;
    endfunction

endpackage

// File: rtl/nmi_port_decode.sv
module nmi_port_decode
    import nmi_pkg::*;
#(
    parameter int ADDR_W    = 16,
    parameter int CTRL_ADDR = 16'h0061,
    parameter int MASK_ADDR = 16'h0070
) (
    input  logic [ADDR_W-1:0] io_addr,
    input  logic              io_wr,
    output port_sel_e         sel,
    output logic              wr_ctrl,
    output logic              wr_mask
);
    localparam logic [ADDR_W-1:0] CTRL_A = ADDR_W'(CTRL_ADDR);
    localparam logic [ADDR_W-1:0] MASK_A = ADDR_W'(MASK_ADDR);

    always_comb begin
        if (io_addr == CTRL_A)      sel = SEL_CTRL;
        else if (io_addr == MASK_A) sel = SEL_MASK;
        else                        sel = SEL_NONE;
    end

    assign wr_ctrl = io_wr && (sel == SEL_CTRL);
    assign wr_mask = io_wr && (sel == SEL_MASK);
endmodule

// File: rtl/nmi_err_source.sv
module nmi_err_source (
    input  logic clk,
    input  logic rst,
    input  logic src_pulse,
    input  logic dis_next,
    output logic stat_q
);
    // the clear (disable) always wins over a pulse arriving in the same cycle
    always_ff @(posedge clk) begin
        if (rst)            stat_q <= 1'b0;
        else if (dis_next)  stat_q <= 1'b0;
        else if (src_pulse) stat_q <= 1'b1;
    end
endmodule

// File: rtl/nmi_refresh_toggle.sv
module nmi_refresh_toggle (
    input  logic clk,
    input  logic rst,
    input  logic refresh_pulse,
    output logic tog_q
);
    always_ff @(posedge clk) begin
        if (rst)                tog_q <= 1'b0;
        else if (refresh_pulse) tog_q <= ~tog_q;
    end
endmodule

// File: rtl/nmi_ctl_top.sv
module nmi_ctl_top
    import nmi_pkg::*;
#(
    parameter int ADDR_W    = 16,
    parameter int CTRL_ADDR = 16'h0061,
    parameter int MASK_ADDR = 16'h0070
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] io_addr,
    input  logic              io_wr,
    input  logic [7:0]        io_wdata,
    output logic [7:0]        io_rdata,
    input  logic              err_pulse,
    input  logic              refresh_pulse,
    input  logic              tmr2_out,
    output logic              tmr2_gate,
    output logic              spkr_out,
    output logic              nmi_out
);
    port_sel_e sel;
    logic      wr_ctrl, wr_mask;
    ctl_wr_t   ctrl_q, ctrl_d;
    mask_t     mask_q;
    logic      err_stat_q, refr_tog_q;

    nmi_port_decode #(
        .ADDR_W    (ADDR_W),
        .CTRL_ADDR (CTRL_ADDR),
        .MASK_ADDR (MASK_ADDR)
    ) u_dec (
        .io_addr (io_addr),
        .io_wr   (io_wr),
        .sel     (sel),
        .wr_ctrl (wr_ctrl),
        .wr_mask (wr_mask)
    );

    // only bits 3:0 are writable; 7:4 of the write data are dropped
    assign ctrl_d = wr_ctrl ? ctl_wr_t'(io_wdata[3:0]) : ctrl_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q <= '0;
            mask_q <= '0;
        end else begin
            ctrl_q <= ctrl_d;
            if (wr_mask) mask_q <= mask_t'(io_wdata);
        end
    end

    nmi_err_source u_err (
        .clk       (clk),
        .rst       (rst),
        .src_pulse (err_pulse),
        .dis_next  (ctrl_d.err_dis),
        .stat_q    (err_stat_q)
    );

    nmi_refresh_toggle u_refr (
        .clk           (clk),
        .rst           (rst),
        .refresh_pulse (refresh_pulse),
        .tog_q         (refr_tog_q)
    );

    always_comb begin
        unique case (sel)
            SEL_CTRL: io_rdata = build_ctl_view(err_stat_q, tmr2_out, refr_tog_q, ctrl_q);
            SEL_MASK: io_rdata = mask_q;
            default:  io_rdata = 8'h00;
        endcase
    end

    assign tmr2_gate = ctrl_q.t2_en;
    assign spkr_out  = ctrl_q.spk_en & tmr2_out;
    assign nmi_out   = err_stat_q & ~mask_q.nmi_off;
endmodule

// File: rtl/nmi_ctl_chk.sv
module nmi_ctl_chk #(
    parameter int ADDR_W    = 16,
    parameter int CTRL_ADDR = 16'h0061
) (
    input logic              clk,
    input logic              rst,
    input logic [ADDR_W-1:0] io_addr,
    input logic              io_wr,
    input logic [7:0]        io_wdata,
    input logic              err_pulse,
    input logic              refresh_pulse,
    input logic              tmr2_out,
    input logic              spkr_out,
    input logic              nmi_out,
    input logic              err_stat,
    input logic              err_dis,
    input logic              nmi_off,
    input logic              refr_tog
);
    logic ctrl_wr;
    assign ctrl_wr = io_wr && (io_addr == ADDR_W'(CTRL_ADDR));

    AST_MASK_FORCES_LOW: assert property (@(posedge clk) disable iff (rst)
        nmi_off |-> !nmi_out); // R8

    AST_CLEAR_WINS: assert property (@(posedge clk) disable iff (rst)
        (ctrl_wr && io_wdata[2]) |=> !err_stat); // R3

    AST_DISABLED_STAYS_CLEAR: assert property (@(posedge clk) disable iff (rst)
        (err_dis && !ctrl_wr) |=> !err_stat); // R3

    AST_PULSE_LATCHES: assert property (@(posedge clk) disable iff (rst)
        (err_pulse && !err_dis && !ctrl_wr) |=> err_stat); // R2

    AST_REFRESH_FLIPS: assert property (@(posedge clk) disable iff (rst)
        refresh_pulse |=> (refr_tog != $past(refr_tog))); // R5

    AST_SPEAKER_GATED: assert property (@(posedge clk) disable iff (rst)
        !tmr2_out |-> !spkr_out); // R6

    AST_LEVEL_HELD: assert property (@(posedge clk) disable iff (rst)
        (nmi_out && !ctrl_wr && !io_wr) |=> nmi_out); // R11
endmodule

bind nmi_ctl_top nmi_ctl_chk #(
    .ADDR_W    (ADDR_W),
    .CTRL_ADDR (CTRL_ADDR)
) u_chk (
    .clk           (clk),
    .rst           (rst),
    .io_addr       (io_addr),
    .io_wr         (io_wr),
    .io_wdata      (io_wdata),
    .err_pulse     (err_pulse),
    .refresh_pulse (refresh_pulse),
    .tmr2_out      (tmr2_out),
    .spkr_out      (spkr_out),
    .nmi_out       (nmi_out),
    .err_stat      (err_stat_q),
    .err_dis       (ctrl_q.err_dis),
    .nmi_off       (mask_q.nmi_off),
    .refr_tog      (refr_tog_q)
);

// File: tb/nmi_ctl_top_tb.sv
`timescale 1ns/1ps
module nmi_ctl_top_tb;
    localparam int ADDR_W = 16;
    localparam logic [15:0] A_CTRL = 16'h0061;
    localparam logic [15:0] A_MASK = 16'h0070;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic [ADDR_W-1:0] io_addr = '0;
    logic              io_wr = 1'b0;
    logic [7:0]        io_wdata = '0;
    logic [7:0]        io_rdata;
    logic              err_pulse = 1'b0;
    logic              refresh_pulse = 1'b0;
    logic              tmr2_out = 1'b0;
    logic              tmr2_gate, spkr_out, nmi_out;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    nmi_ctl_top u_dut (
        .clk           (clk),
        .rst           (rst),
        .io_addr       (io_addr),
        .io_wr         (io_wr),
        .io_wdata      (io_wdata),
        .io_rdata      (io_rdata),
        .err_pulse     (err_pulse),
        .refresh_pulse (refresh_pulse),
        .tmr2_out      (tmr2_out),
        .tmr2_gate     (tmr2_gate),
        .spkr_out      (spkr_out),
        .nmi_out       (nmi_out)
    );

    task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %02h expected %02h", tag, act, exp);
        end
    endtask

    task automatic io_write(input logic [15:0] a, input logic [7:0] d);
        @(negedge clk);
        io_addr = a; io_wdata = d; io_wr = 1'b1;
        @(negedge clk);
        io_wr = 1'b0;
    endtask

    task automatic io_read(input logic [15:0] a, output logic [7:0] d);
        @(negedge clk);
        io_addr = a;
        #2;
        d = io_rdata;
    endtask

    task automatic pulse_err();
        @(negedge clk);
        err_pulse = 1'b1;
        @(negedge clk);
        err_pulse = 1'b0;
    endtask

    task automatic pulse_refresh();
        @(negedge clk);
        refresh_pulse = 1'b1;
        @(negedge clk);
        refresh_pulse = 1'b0;
    endtask

    task automatic t_reset();
        logic [7:0] d;
        io_read(A_CTRL, d); check("R1 ctrl after reset", d, 8'h00);
        io_read(A_MASK, d); check("R1 mask after reset", d, 8'h00);
        check("R1 nmi after reset", {7'd0, nmi_out}, 8'h00);
        check("R1 gate/spkr after reset", {6'd0, tmr2_gate, spkr_out}, 8'h00);
    endtask

    task automatic t_ctrl_bits();
        logic [7:0] d;
        io_write(A_CTRL, 8'h0B);
        io_read(A_CTRL, d); check("R7 bits 3,1,0 stored", d, 8'h0B);
        check("R7 timer gate", {7'd0, tmr2_gate}, 8'h01);
        io_write(A_CTRL, 8'hFB);
        io_read(A_CTRL, d); check("R9 upper write bits ignored", d, 8'h0B);
        check("R9 nmi unaffected", {7'd0, nmi_out}, 8'h00);
    endtask

    task automatic t_timer();
        logic [7:0] d;
        tmr2_out = 1'b1;
        io_read(A_CTRL, d); check("R4 live timer level high", d, 8'h2B);
        check("R6 speaker follows timer", {7'd0, spkr_out}, 8'h01);
        io_write(A_CTRL, 8'h09);
        check("R6 speaker gated off", {7'd0, spkr_out}, 8'h00);
        io_read(A_CTRL, d); check("R4 read with speaker off", d, 8'h29);
        tmr2_out = 1'b0;
        io_read(A_CTRL, d); check("R4 live timer level low", d, 8'h09);
        io_write(A_CTRL, 8'h00);
        check("R7 timer gate off", {7'd0, tmr2_gate}, 8'h00);
        io_write(A_CTRL, 8'h09);
    endtask

    task automatic t_err();
        logic [7:0] d;
        pulse_err();
        check("R2 nmi after pulse", {7'd0, nmi_out}, 8'h01);
        io_read(A_CTRL, d); check("R2 status bit 7 set", d, 8'h89);
        io_write(A_CTRL, 8'h0D);
        check("R3 nmi after clear", {7'd0, nmi_out}, 8'h00);
        io_read(A_CTRL, d); check("R3 status cleared", d, 8'h0D);
        pulse_err();
        io_read(A_CTRL, d); check("R3 pulse dropped while disabled", d, 8'h0D);
        check("R3 nmi stays low while disabled", {7'd0, nmi_out}, 8'h00);
        io_write(A_CTRL, 8'h09);
        io_read(A_CTRL, d); check("R3 re-enable does not set", d, 8'h09);
        pulse_err();
        io_read(A_CTRL, d); check("R2 pulse latched again", d, 8'h89);
        // clear write and pulse in the same cycle
        @(negedge clk);
        io_addr = A_CTRL; io_wdata = 8'h0D; io_wr = 1'b1; err_pulse = 1'b1;
        @(negedge clk);
        io_wr = 1'b0; err_pulse = 1'b0;
        io_read(A_CTRL, d); check("R3 clear wins over pulse", d, 8'h0D);
        check("R3 nmi low after clear race", {7'd0, nmi_out}, 8'h00);
        io_write(A_CTRL, 8'h09);
    endtask

    task automatic t_mask();
        logic [7:0] d;
        pulse_err();
        check("R11 nmi high", {7'd0, nmi_out}, 8'h01);
        @(negedge clk);
        err_pulse = 1'b1;
        #2 check("R11 level held during second pulse", {7'd0, nmi_out}, 8'h01);
        @(negedge clk);
        err_pulse = 1'b0;
        check("R11 level held after second pulse", {7'd0, nmi_out}, 8'h01);
        io_write(A_MASK, 8'h80);
        check("R8 mask forces low", {7'd0, nmi_out}, 8'h00);
        io_read(A_MASK, d); check("R8 mask readback", d, 8'h80);
        pulse_err();
        check("R8 masked pulse stays low", {7'd0, nmi_out}, 8'h00);
        io_write(A_MASK, 8'h05);
        check("R11 unmask re-raises level", {7'd0, nmi_out}, 8'h01);
        io_read(A_MASK, d); check("R8 scratch bits readback", d, 8'h05);
        io_write(A_CTRL, 8'h0D);
        io_write(A_CTRL, 8'h09);
        check("R3 nmi low after service", {7'd0, nmi_out}, 8'h00);
    endtask

    task automatic t_other();
        logic [7:0] d;
        io_write(16'h0062, 8'hFF);
        io_write(16'h0071, 8'hFF);
        io_read(A_CTRL, d); check("R10 ctrl untouched by 062h", d, 8'h09);
        io_read(A_MASK, d); check("R10 mask untouched by 071h", d, 8'h05);
        io_read(16'h0062, d); check("R10 unmapped read 062h", d, 8'h00);
        io_read(16'h0071, d); check("R10 unmapped read 071h", d, 8'h00);
    endtask

    task automatic t_refresh();
        logic [7:0] d;
        pulse_refresh();
        io_read(A_CTRL, d); check("R5 toggle after one pulse", d, 8'h19);
        pulse_refresh();
        io_read(A_CTRL, d); check("R5 toggle after two pulses", d, 8'h09);
        pulse_refresh();
        io_read(A_CTRL, d); check("R5 toggle after three pulses", d, 8'h19);
        io_write(A_CTRL, 8'h19);
        io_read(A_CTRL, d); check("R9 write to bit 4 ignored", d, 8'h19);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_ctrl_bits();
        t_timer();
        t_err();
        t_mask();
        t_other();
        t_refresh();
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        #(200000 * 20);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual hung expected done");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end
endmodule